// File: doc/BRIEF.md
# Receive Completion Status Queue

This block sits between a receive DMA engine and the CPU. Each time the DMA engine finishes writing a received frame to memory, it pushes one 32-bit completion word into the queue. The upper half of the word holds the frame status flags. The lower half holds the number of bytes transferred. Every transfer starts with 2 alignment pad bytes, so the transferred count is always the frame length plus 2. Software drains the queue through a small register port, and reading the status register is itself the pop. A read of the status register is therefore never a harmless probe.

The push side is a valid/ready stream that cannot stall. `push_ready` is high whenever the queue has a free slot. A word offered while `push_ready` is low is lost, and a sticky overflow bit records the loss. `push_ready` does not look at a pop in the same cycle, so a full queue refuses a push even while it is being read. The register side has four word registers, chosen by `reg_addr`:

- 0: the status register. Reading it pops the oldest entry.
- 1: the control register. Bit 0 enables the interrupt.
- 2: a read-only information register. It holds the frame length and error class of the most recently consumed entry, and the empty, overflow and pending bits.
- 3: a write-only clear register.

The interrupt is a level that is high while the interrupt is enabled and the queue holds data. Alongside the level, a pending flag latches each transition of the queue from empty to not empty.

Top module: `rxq_status_queue`

## Requirements
- R1: The queue stores each pushed word verbatim, with status flags in bits 31:16 and byte count in bits 15:0. Successive status reads return the words oldest first. `reg_rdata` carries the value in the cycle after the read.
- R2: A read of register 0 with data present removes exactly one entry. Reads of registers 1, 2 and 3 never remove an entry.
- R3: A read of register 0 while the queue is empty returns 32'h0 and leaves all state unchanged.
- R4: `push_ready` is high exactly when fewer than DEPTH entries are held. A word is stored when `push_valid` and `push_ready` are both high.
- R5: When `push_valid` is high and `push_ready` is low, the word is dropped and the overflow bit (register 2 bit 18) is set. Writing register 3 with bit 1 set clears the overflow bit. A drop in the same cycle as that clear leaves the bit set. Register 3 reads as 0.
- R6: A push and a status read may occur in the same cycle:
  - On an empty queue, the read returns 0 and the word is stored.
  - On a partly filled queue, the head is returned, the word is stored, and the occupancy is unchanged.
  - On a full queue, the head is returned and the word is dropped as in R5.
- R7: Register 2 bits 15:0 hold the frame length of the most recently consumed entry. This is the byte count minus 2, or 0 when the count is below 2. The value is 0 after reset.
- R8: Register 2 bit 16 is set when the most recently consumed entry was errored, meaning bits 23:16 are nonzero or bits 15:0 are zero. An errored entry is still consumed.
- R9: Register 1 bit 0 is the interrupt enable; it is writable and reads back. `irq` is high exactly when the enable is set and the queue is not empty.
- R10: The pending flag (register 2 bit 19) sets one cycle after the queue goes from empty to not empty. Writing register 3 with bit 0 set clears it. A set in the same cycle as a clear wins.
- R11: After reset:
  - the queue is empty (register 2 bit 17 is set) and `push_ready` is high;
  - `irq` is low;
  - all other register bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Completion word offered by the DMA engine |
| push_ready | output | 1 | A free slot exists; the offered word is taken |
| push_data | input | 32 | Completion word: flags 31:16, byte count 15:0 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd`, otherwise 0 |
| irq | output | 1 | Interrupt level |

## Verification
The functions that can collide are the DMA push and the consuming status read. The bench presents both in one cycle with the queue empty, partly filled and full, on a four-entry configuration. It checks the returned word, what later reads drain, and the overflow bit against a bench-side queue model. It also lands an overflow drop on the same cycle as an overflow clear, and a pending set on the same cycle as a pending clear, and expects the set to win in both cases.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_CTRL = 2'd1,
    REG_INFO = 2'd2,
    REG_CLR  = 2'd3
  } rxq_reg_e;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 16;
  localparam int ERR_LSB = 16;
  localparam int ERR_W   = 8;

  // An entry counts as errored when its low flag byte is nonzero or its byte count is zero.
  function automatic logic word_is_bad(input logic [WORD_W-1:0] w);
    return (w[ERR_LSB +: ERR_W] != '0) || (w[CNT_W-1:0] == '0);
  endfunction

  // Frame length after removing the leading pad bytes, floored at zero.
  function automatic logic [CNT_W-1:0] strip_pad(input logic [CNT_W-1:0] cnt,
                                                 input logic [CNT_W-1:0] pad);
    return (cnt >= pad) ? cnt - pad : '0;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 64,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CAP);

  assert_no_write_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  assert_no_read_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
  assert_swap_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(cnt));

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_we,
  input  logic en_d,
  input  logic pend_clr,
  input  logic nonempty,
  output logic irq,
  output logic en_o,
  output logic pend_o
);
  logic en_q, ne_q, pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ne_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_d;
      ne_q <= nonempty;
      if (nonempty && !ne_q) pend_q <= 1'b1;
      else if (pend_clr)     pend_q <= 1'b0;
    end
  end

  assign irq    = en_q & nonempty;
  assign en_o   = en_q;
  assign pend_o = pend_q;

  assert_pend_on_arrival_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nonempty && !ne_q) |=> pend_q);
  assert_pend_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !pend_clr) |=> pend_q);
  assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(en_d)));

endmodule

// File: rtl/rxq_status_queue.sv
module rxq_status_queue #(
  parameter int DEPTH     = 64,
  parameter int PAD_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  output logic        push_ready,
  input  logic [31:0] push_data,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  import rxq_pkg::*;

  localparam logic [CNT_W-1:0] PAD_W = CNT_W'(PAD_BYTES);

  rxq_reg_e          sel;
  logic              empty, full, do_push, do_pop;
  logic [WORD_W-1:0] head;
  logic              ovf_q, last_err_q;
  logic [CNT_W-1:0]  last_len_q;
  logic              clr_wr, clr_pend, clr_ovf;
  logic              irq_en, pend;
  logic [WORD_W-1:0] info_word;
  logic              unused_wdata;

  assign sel          = rxq_reg_e'(reg_addr);
  assign push_ready   = !full;
  assign do_push      = push_valid && push_ready;
  assign do_pop       = reg_rd && (sel == REG_STAT) && !empty;
  assign clr_wr       = reg_wr && (sel == REG_CLR);
  assign clr_pend     = clr_wr && reg_wdata[0];
  assign clr_ovf      = clr_wr && reg_wdata[1];
  assign unused_wdata = ^reg_wdata[31:2];

  rxq_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (do_push),
    .wr_data (push_data),
    .rd_en   (do_pop),
    .head    (head),
    .empty   (empty),
    .full    (full)
  );

  rxq_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (reg_wr && (sel == REG_CTRL)),
    .en_d     (reg_wdata[0]),
    .pend_clr (clr_pend),
    .nonempty (!empty),
    .irq      (irq),
    .en_o     (irq_en),
    .pend_o   (pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q      <= 1'b0;
      last_err_q <= 1'b0;
      last_len_q <= '0;
    end else begin
      if (push_valid && !push_ready) ovf_q <= 1'b1;
      else if (clr_ovf)              ovf_q <= 1'b0;
      if (do_pop) begin
        last_err_q <= word_is_bad(head);
        last_len_q <= strip_pad(head[CNT_W-1:0], PAD_W);
      end
    end
  end

  assign info_word = {12'd0, pend, ovf_q, empty, last_err_q, last_len_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (sel)
        REG_STAT: reg_rdata <= empty ? '0 : head;
        REG_CTRL: reg_rdata <= {31'd0, irq_en};
        REG_INFO: reg_rdata <= info_word;
        default:  reg_rdata <= '0;
      endcase
    end else begin
      reg_rdata <= '0;
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> ovf_q);
  assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q);
  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (sel == REG_STAT) && empty) |=> (reg_rdata == '0));
  assert_irq_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (push_ready || !empty) && !empty);
  assert_pop_records_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> (last_len_q <= $past(head[CNT_W-1:0])));

endmodule

// File: tb/test_rxq_status_queue.sv
module test_rxq_status_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid, push_ready;
  logic [31:0] push_data;
  logic        reg_rd, reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [31:0] mq[$];
  logic        m_ovf, m_en, m_pend, m_prev, m_err;
  logic [15:0] m_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_status_queue #(.DEPTH(DEPTH), .PAD_BYTES(2)) i_rxq_status_queue (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wgen(input int k);
    logic [7:0] bad;
    bad = (k % 3 == 1) ? 8'((k | 1) & 8'hff) : 8'h00;
    return {8'((k * 37 + 5) & 8'hff), bad, 16'(k)};
  endfunction

  // One cycle: drive at a falling edge, let the rising edge act, compare at the next falling edge.
  task automatic step(input logic pv, input logic [31:0] pd, input logic rd,
                      input logic wr, input logic [1:0] a, input logic [31:0] wd,
                      input string tag);
    logic [31:0] exp_rd, w;
    bit emp, ful, pop, cur_ne;
    emp = (mq.size() == 0);
    ful = (mq.size() == DEPTH);
    exp_rd = '0;
    if (rd) begin
      case (a)
        2'd0: exp_rd = emp ? 32'h0 : mq[0];
        2'd1: exp_rd = {31'd0, m_en};
        2'd2: exp_rd = {12'd0, m_pend, m_ovf, emp, m_err, m_len};
        default: exp_rd = '0;
      endcase
    end
    push_valid = pv; push_data = pd; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    pop = rd && (a == 2'd0) && !emp;
    cur_ne = !emp;
    if (pop) begin
      w = mq.pop_front();
      m_len = (w[15:0] >= 16'd2) ? w[15:0] - 16'd2 : 16'd0;
      m_err = (w[23:16] != 8'd0) || (w[15:0] == 16'd0);
    end
    if (pv && !ful) mq.push_back(pd);
    if (pv && ful) m_ovf = 1'b1;
    else if (wr && a == 2'd3 && wd[1]) m_ovf = 1'b0;
    if (wr && a == 2'd1) m_en = wd[0];
    if (cur_ne && !m_prev) m_pend = 1'b1;
    else if (wr && a == 2'd3 && wd[0]) m_pend = 1'b0;
    m_prev = cur_ne;
    if (rd) check(tag, reg_rdata, exp_rd);
    check("R4 push_ready", {31'd0, push_ready}, {31'd0, mq.size() < DEPTH});
    check("R9 irq", {31'd0, irq}, {31'd0, m_en && (mq.size() > 0)});
    push_valid = 0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic push(input logic [31:0] d);  step(1, d, 0, 0, 2'd0, 0, "R4"); endtask
  task automatic rd_stat(input string t);      step(0, 0, 1, 0, 2'd0, 0, t);    endtask
  task automatic rd_info(input string t);      step(0, 0, 1, 0, 2'd2, 0, t);    endtask
  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d, input string t);
    step(0, 0, 0, 1, a, d, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int base;
    push_valid = 0; push_data = 0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    m_ovf = 0; m_en = 0; m_pend = 0; m_prev = 0; m_err = 0; m_len = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11: state after reset
    check("R11 ready", {31'd0, push_ready}, 32'd1);
    check("R11 irq", {31'd0, irq}, 32'd0);
    rd_info("R11 info");
    check("R11 info word", reg_rdata, 32'h0002_0000);
    step(0, 0, 1, 0, 2'd1, 0, "R11 ctrl");
    check("R11 ctrl word", reg_rdata, 32'h0);

    // R3: status read on an empty queue
    rd_stat("R3 empty read");
    check("R3 zero", reg_rdata, 32'h0);
    rd_info("R3 info unchanged");
    check("R3 info word", reg_rdata, 32'h0002_0000);

    // R1, R2, R7, R8: sweep every fill level with varied counts and flags
    base = 0;
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) push(wgen(base + i));
      rd_info("R2 info read keeps entries");
      step(0, 0, 1, 0, 2'd1, 0, "R2 ctrl read keeps entries");
      step(0, 0, 1, 0, 2'd3, 0, "R5 clr reads zero");
      for (int i = 0; i < n; i++) begin
        rd_stat("R1 order");
        check("R1 word", reg_rdata, wgen(base + i));
        rd_info("R7 length");
        check("R7 len", {16'd0, reg_rdata[15:0]},
              {16'd0, ((base + i) >= 2) ? 16'(base + i - 2) : 16'd0});
        check("R8 err", {31'd0, reg_rdata[16]},
              {31'd0, ((base + i) % 3 == 1) || (base + i == 0)});
      end
      rd_stat("R2 drained");
      check("R2 empty after drain", reg_rdata, 32'h0);
      base += n;
    end

    // R5: drop on full, sticky bit, clear, drop beats clear
    for (int i = 0; i < DEPTH; i++) push(wgen(40 + i));
    check("R5 ready low when full", {31'd0, push_ready}, 32'd0);
    push(32'hDEAD_0099);
    rd_info("R5 overflow set");
    check("R5 ovf bit", {31'd0, reg_rdata[18]}, 32'd1);
    step(1, 32'hBEEF_0077, 0, 1, 2'd3, 32'h2, "R5 drop with clear");
    rd_info("R5 set wins");
    check("R5 ovf kept", {31'd0, reg_rdata[18]}, 32'd1);
    wr_reg(2'd3, 32'h2, "R5 clear");
    rd_info("R5 cleared");
    check("R5 ovf clear", {31'd0, reg_rdata[18]}, 32'd0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_stat("R5 survivors");
      check("R5 survivor", reg_rdata, wgen(40 + i));
    end
    rd_stat("R5 dropped word absent");
    check("R5 nothing extra", reg_rdata, 32'h0);

    // R6: push and status read in the same cycle
    step(1, wgen(50), 1, 0, 2'd0, 0, "R6 empty collide");
    check("R6 empty returns zero", reg_rdata, 32'h0);
    push(wgen(51));
    step(1, wgen(52), 1, 0, 2'd0, 0, "R6 mid collide");
    check("R6 mid head", reg_rdata, wgen(50));
    rd_stat("R6 mid next");
    check("R6 mid order", reg_rdata, wgen(51));
    push(wgen(53)); push(wgen(54)); push(wgen(55));
    step(1, wgen(56), 1, 0, 2'd0, 0, "R6 full collide");
    check("R6 full head", reg_rdata, wgen(52));
    rd_info("R6 full drop flagged");
    check("R6 ovf", {31'd0, reg_rdata[18]}, 32'd1);
    for (int k = 53; k <= 55; k++) begin
      rd_stat("R6 drain");
      check("R6 drained word", reg_rdata, wgen(k));
    end
    rd_stat("R6 full push dropped");
    check("R6 no extra", reg_rdata, 32'h0);
    wr_reg(2'd3, 32'h3, "R5 clear all");

    // R9, R10: interrupt level and pending latch
    wr_reg(2'd1, 32'h1, "R9 enable");
    step(0, 0, 1, 0, 2'd1, 0, "R9 enable readback");
    check("R9 en bit", reg_rdata, 32'h1);
    check("R9 idle empty", {31'd0, irq}, 32'd0);
    push(wgen(60));
    check("R9 irq on data", {31'd0, irq}, 32'd1);
    step(0, 0, 1, 1, 2'd3, 32'h1, "R10 set wins over clear");
    rd_info("R10 pending");
    check("R10 pend set", {31'd0, reg_rdata[19]}, 32'd1);
    wr_reg(2'd3, 32'h1, "R10 clear");
    rd_info("R10 cleared");
    check("R10 pend clear", {31'd0, reg_rdata[19]}, 32'd0);
    check("R9 level stays", {31'd0, irq}, 32'd1);
    push(wgen(61));
    rd_info("R10 no new edge");
    check("R10 pend stays low", {31'd0, reg_rdata[19]}, 32'd0);
    wr_reg(2'd1, 32'h0, "R9 disable");
    check("R9 masked", {31'd0, irq}, 32'd0);
    wr_reg(2'd1, 32'h1, "R9 re-enable");
    rd_stat("R1 pop a");
    rd_stat("R1 pop b");
    check("R9 drained", {31'd0, irq}, 32'd0);
    push(wgen(62));
    step(0, 0, 0, 0, 2'd0, 0, "R10 idle");
    rd_info("R10 re-arm");
    check("R10 pend again", {31'd0, reg_rdata[19]}, 32'd1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule